// File: doc/BRIEF.md
# Key store hash verification controller

This block confirms that a small non-volatile key store has not been altered. Software writes a 1 to a verify-request control bit. The block then fetches the key words one by one from a synchronous memory read port. It feeds them through an on-chip SHA-1 engine, with the message padding generated in hardware. The 160-bit result is compared against a reference digest kept in the same memory, directly after the keys.

A 3-bit status readout carries the request bit, a done flag and a pass flag. Hardware drops the request bit on the same clock edge that raises done. The pass flag carries meaning only while done is set. The key region is given by a start address and a word count, both sampled when a run is accepted.

Top module: `keyhash_verify`

## Requirements
- R1: After reset, `stat_rdata` is 0 (bit 0 request, bit 1 done, bit 2 pass) and `mem_rd_en` is low.
- R2: A clock edge with `ctl_wr`=1 and `ctl_wdata`=1 while the request bit is 0 sets the request bit and clears done and pass in that same edge. It also latches `cfg_base` and `cfg_count`.
- R3: A run reads exactly `cfg_count` key words from addresses `cfg_base`+i in ascending i. It then reads five digest words from `cfg_base`+`cfg_count`+j, j=0..4. Addresses wrap modulo 2^ADDR_W, and read data is taken one cycle after `mem_rd_en`.
- R4: Pass is 1 when the stored digest equals SHA-1 of the key words, taken as a big-endian 32-bit word message of `cfg_count`*32 bits. Digest word H0 sits at the lowest reference address and H4 at the highest.
- R5: A difference in any bit of the five reference words yields pass = 0.
- R6: On completion, done rises and the request bit falls on the same edge.
- R7: Pass reads 0 whenever done is 0.
- R8: A write of 1 while the request bit is set has no effect: no restart and no extra reads. A write with `ctl_wdata`=0 never has an effect.
- R9: Padding appends one 1 bit, pads with zeros to 448 mod 512, and then appends a 64-bit length. This gives ceil((count+3)/16) blocks, so counts of 14 and 15 words spill into an extra block, and a count of 0 hashes the empty message.
- R10: Done and pass hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 1 | Value written to the verify-request bit |
| stat_rdata | output | 3 | {pass, done, request} |
| cfg_base | input | ADDR_W | First key word address |
| cfg_count | input | CNT_W | Number of key words |
| mem_rd_en | output | 1 | Key memory read strobe |
| mem_addr | output | ADDR_W | Key memory read address |
| mem_rdata | input | 32 | Key memory read data, one cycle after the strobe |

## Verification
A wrong word in the fetch stream, a wrong padding word, a slipped round constant or a bad message-schedule tap all corrupt the whole 160-bit digest. The result shows up at the end of the run as a pass flag that disagrees with a digest the bench computes itself. That happens within about a hundred cycles per 512-bit block. Sweeping every word count from 0 to 20 places the 1 bit and the length words at every position inside a block and across the spill into an extra block. Wrong sequencing shows directly on the memory port, as a read address that is out of order or out of range, or as a read count other than count+5. A wrong control state shows within one cycle of a write, as a request, done or pass bit with the wrong value.

// File: rtl/kv_pkg.sv
package kv_pkg;
    localparam int WORD_W = 32;
    localparam int DIG_WORDS = 5;
    localparam int BLK_WORDS = 16;
    localparam int ROUNDS = 80;
    localparam logic [WORD_W-1:0] PAD_ONE = 32'h8000_0000;

    typedef enum logic [2:0] {
        S_IDLE, S_FILL, S_KICK, S_GO, S_HASH, S_REF, S_TAIL
    } seq_state_e;

    function automatic logic [DIG_WORDS-1:0][WORD_W-1:0] sha1_iv();
        logic [DIG_WORDS-1:0][WORD_W-1:0] r;
        r[0] = 32'h6745_2301;
        r[1] = 32'hEFCD_AB89;
        r[2] = 32'h98BA_DCFE;
        r[3] = 32'h1032_5476;
        r[4] = 32'hC3D2_E1F0;
        return r;
    endfunction
endpackage

// File: rtl/kv_sha1_round.sv
module kv_sha1_round
    import kv_pkg::*;
(
    input  logic [DIG_WORDS-1:0][WORD_W-1:0] v_in,
    input  logic [WORD_W-1:0]                w_in,
    input  logic [6:0]                       t_in,
    output logic [DIG_WORDS-1:0][WORD_W-1:0] v_out
);
    logic [WORD_W-1:0] f_val;
    logic [WORD_W-1:0] k_val;
    logic [WORD_W-1:0] tmp;

    always_comb begin
        if (t_in < 7'd20) begin
            f_val = (v_in[1] & v_in[2]) | (~v_in[1] & v_in[3]);
            k_val = 32'h5A82_7999;
        end else if (t_in < 7'd40) begin
            f_val = v_in[1] ^ v_in[2] ^ v_in[3];
            k_val = 32'h6ED9_EBA1;
        end else if (t_in < 7'd60) begin
            f_val = (v_in[1] & v_in[2]) | (v_in[1] & v_in[3]) | (v_in[2] & v_in[3]);
            k_val = 32'h8F1B_BCDC;
        end else begin
            f_val = v_in[1] ^ v_in[2] ^ v_in[3];
            k_val = 32'hCA62_C1D6;
        end
        tmp = {v_in[0][26:0], v_in[0][31:27]} + f_val + v_in[4] + k_val + w_in;
        v_out[0] = tmp;
        v_out[1] = v_in[0];
        v_out[2] = {v_in[1][1:0], v_in[1][31:2]};
        v_out[3] = v_in[2];
        v_out[4] = v_in[3];
    end
endmodule

// File: rtl/kv_sha1_core.sv
module kv_sha1_core
    import kv_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 init,
    input  logic                 shift_en,
    input  logic [WORD_W-1:0]    shift_word,
    input  logic                 go,
    output logic                 busy,
    output logic [DIG_WORDS*WORD_W-1:0] digest
);
    typedef struct packed {
        logic [BLK_WORDS-1:0][WORD_W-1:0] w;
        logic [DIG_WORDS-1:0][WORD_W-1:0] h;
        logic [DIG_WORDS-1:0][WORD_W-1:0] v;
        logic [6:0]                       rnd;
        logic                             busy;
    } core_t;

    core_t q, d;
    logic [DIG_WORDS-1:0][WORD_W-1:0] v_nx;
    logic [WORD_W-1:0] w_mix;
    logic [WORD_W-1:0] w_new;

    kv_sha1_round u_round (
        .v_in  (q.v),
        .w_in  (q.w[0]),
        .t_in  (q.rnd),
        .v_out (v_nx)
    );

    always_comb begin
        d     = q;
        w_mix = q.w[13] ^ q.w[8] ^ q.w[2] ^ q.w[0];
        w_new = {w_mix[30:0], w_mix[31]};
        if (init) begin
            d.h = sha1_iv();
        end
        if (shift_en) begin
            d.w = {shift_word, q.w[BLK_WORDS-1:1]};
        end
        if (go) begin
            d.v    = q.h;
            d.busy = 1'b1;
            d.rnd  = '0;
        end else if (q.busy) begin
            d.v   = v_nx;
            d.w   = {w_new, q.w[BLK_WORDS-1:1]};
            d.rnd = q.rnd + 7'd1;
            if (q.rnd == 7'(ROUNDS - 1)) begin
                d.busy = 1'b0;
                for (int i = 0; i < DIG_WORDS; i++) begin
                    d.h[i] = q.h[i] + v_nx[i];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy   = q.busy;
    assign digest = {q.h[0], q.h[1], q.h[2], q.h[3], q.h[4]};
endmodule

// File: rtl/kv_seq.sv
module kv_seq
    import kv_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctl_wr,
    input  logic                 ctl_wdata,
    input  logic [ADDR_W-1:0]    cfg_base,
    input  logic [CNT_W-1:0]     cfg_count,
    output logic                 mem_rd_en,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic [WORD_W-1:0]    mem_rdata,
    output logic                 core_init,
    output logic                 core_shift,
    output logic [WORD_W-1:0]    core_word,
    output logic                 core_go,
    input  logic                 core_busy,
    input  logic [DIG_WORDS*WORD_W-1:0] core_digest,
    output logic                 st_req,
    output logic                 st_done,
    output logic                 st_pass
);
    localparam int WIDX_W = CNT_W + 2;

    typedef struct packed {
        seq_state_e          state;
        logic                req;
        logic                done;
        logic                pass;
        logic [ADDR_W-1:0]   base;
        logic [CNT_W-1:0]    cnt;
        logic [WIDX_W-1:0]   nb;
        logic [WIDX_W-1:0]   blk;
        logic [WIDX_W-1:0]   widx;
        logic [3:0]          pos;
        logic [2:0]          ridx;
        logic                ev;
        logic                emem;
        logic [WORD_W-1:0]   epad;
        logic                cv;
        logic [2:0]          csel;
        logic                mism;
    } seq_t;

    seq_t q, d;
    logic [63:0]        len_bits;
    logic               cmp_bad;
    logic [WORD_W-1:0]  ref_word;
    logic               last_blk;

    always_comb begin
        case (q.csel)
            3'd0:    ref_word = core_digest[159:128];
            3'd1:    ref_word = core_digest[127:96];
            3'd2:    ref_word = core_digest[95:64];
            3'd3:    ref_word = core_digest[63:32];
            default: ref_word = core_digest[31:0];
        endcase
    end

    always_comb begin
        d         = q;
        core_init = 1'b0;
        core_go   = 1'b0;
        mem_rd_en = 1'b0;
        mem_addr  = '0;
        len_bits  = 64'(q.cnt) << 5;
        last_blk  = (q.blk == q.nb - WIDX_W'(1));
        core_shift = q.ev;
        core_word  = q.emem ? mem_rdata : q.epad;
        cmp_bad    = q.cv && (mem_rdata != ref_word);
        d.ev = 1'b0;
        d.cv = 1'b0;
        if (cmp_bad) d.mism = 1'b1;

        case (q.state)
            S_IDLE: begin
                if (ctl_wr && ctl_wdata) begin
                    d.req   = 1'b1;
                    d.done  = 1'b0;
                    d.pass  = 1'b0;
                    d.base  = cfg_base;
                    d.cnt   = cfg_count;
                    d.nb    = (WIDX_W'(cfg_count) + WIDX_W'(18)) >> 4;
                    d.blk   = '0;
                    d.widx  = '0;
                    d.pos   = '0;
                    d.mism  = 1'b0;
                    core_init = 1'b1;
                    d.state = S_FILL;
                end
            end
            S_FILL: begin
                d.ev = 1'b1;
                if (q.widx < WIDX_W'(q.cnt)) begin
                    mem_rd_en = 1'b1;
                    mem_addr  = q.base + ADDR_W'(q.widx);
                    d.emem    = 1'b1;
                end else begin
                    d.emem = 1'b0;
                end
                if (q.widx == WIDX_W'(q.cnt))           d.epad = PAD_ONE;
                else if (last_blk && q.pos == 4'd14)     d.epad = len_bits[63:32];
                else if (last_blk && q.pos == 4'd15)     d.epad = len_bits[31:0];
                else                                     d.epad = '0;
                d.widx = q.widx + WIDX_W'(1);
                d.pos  = q.pos + 4'd1;
                if (q.pos == 4'd15) d.state = S_KICK;
            end
            S_KICK: d.state = S_GO;
            S_GO: begin
                core_go = 1'b1;
                d.state = S_HASH;
            end
            S_HASH: begin
                if (!core_busy) begin
                    if (last_blk) begin
                        d.ridx  = '0;
                        d.state = S_REF;
                    end else begin
                        d.blk   = q.blk + WIDX_W'(1);
                        d.state = S_FILL;
                    end
                end
            end
            S_REF: begin
                mem_rd_en = 1'b1;
                mem_addr  = q.base + ADDR_W'(q.cnt) + ADDR_W'(q.ridx);
                d.cv      = 1'b1;
                d.csel    = q.ridx;
                d.ridx    = q.ridx + 3'd1;
                if (q.ridx == 3'(DIG_WORDS - 1)) d.state = S_TAIL;
            end
            S_TAIL: begin
                d.done  = 1'b1;
                d.pass  = !(q.mism || cmp_bad);
                d.req   = 1'b0;
                d.state = S_IDLE;
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign st_req  = q.req;
    assign st_done = q.done;
    assign st_pass = q.pass;
endmodule

// File: rtl/keyhash_verify.sv
module keyhash_verify
    import kv_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              ctl_wdata,
    output logic [2:0]        stat_rdata,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [CNT_W-1:0]  cfg_count,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [31:0]       mem_rdata
);
    logic                 core_init;
    logic                 core_shift;
    logic [WORD_W-1:0]    core_word;
    logic                 core_go;
    logic                 core_busy;
    logic [DIG_WORDS*WORD_W-1:0] core_digest;
    logic                 st_req;
    logic                 st_done;
    logic                 st_pass;

    kv_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_wr      (ctl_wr),
        .ctl_wdata   (ctl_wdata),
        .cfg_base    (cfg_base),
        .cfg_count   (cfg_count),
        .mem_rd_en   (mem_rd_en),
        .mem_addr    (mem_addr),
        .mem_rdata   (mem_rdata),
        .core_init   (core_init),
        .core_shift  (core_shift),
        .core_word   (core_word),
        .core_go     (core_go),
        .core_busy   (core_busy),
        .core_digest (core_digest),
        .st_req      (st_req),
        .st_done     (st_done),
        .st_pass     (st_pass)
    );

    kv_sha1_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .init       (core_init),
        .shift_en   (core_shift),
        .shift_word (core_word),
        .go         (core_go),
        .busy       (core_busy),
        .digest     (core_digest)
    );

    assign stat_rdata = {st_pass, st_done, st_req};
endmodule

// File: rtl/keyhash_verify_chk.sv
module keyhash_verify_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_wr,
    input logic       ctl_wdata,
    input logic [2:0] stat_rdata,
    input logic       mem_rd_en
);
    a_r7_pass_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rdata[2] |-> stat_rdata[1]);

    a_r6_done_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_rdata[1]) |-> !stat_rdata[0]);

    a_r6_req_falls_only_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_rdata[0]) |-> stat_rdata[1]);

    a_r2_start_clears_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_rdata[0] && ctl_wr && ctl_wdata) |=> (stat_rdata[0] && !stat_rdata[1] && !stat_rdata[2]));

    a_r3_no_reads_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rdata[0] |-> !mem_rd_en);

    a_r10_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rdata[1] && !(ctl_wr && ctl_wdata)) |=> (stat_rdata[1] && $stable(stat_rdata[2])));

    a_r8_zero_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_rdata[0] && !(ctl_wr && ctl_wdata)) |=> !stat_rdata[0]);
endmodule

bind keyhash_verify keyhash_verify_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr     (ctl_wr),
    .ctl_wdata  (ctl_wdata),
    .stat_rdata (stat_rdata),
    .mem_rd_en  (mem_rd_en)
);

// File: tb/keyhash_verify_tb.sv
`timescale 1ns/1ps
module keyhash_verify_tb;
    localparam int AW = 6;
    localparam int CW = 5;
    localparam int MSZ = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_wr = 1'b0;
    logic          ctl_wdata = 1'b0;
    logic [2:0]    stat_rdata;
    logic [AW-1:0] cfg_base = '0;
    logic [CW-1:0] cfg_count = '0;
    logic          mem_rd_en;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_rdata = '0;

    logic [31:0]   mem [MSZ];
    int            rd_log [64];
    int            nlog = 0;
    int            n_chk = 0;
    int            n_bad = 0;

    always #4 clk = ~clk;

    keyhash_verify #(.ADDR_W(AW), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .stat_rdata(stat_rdata), .cfg_base(cfg_base), .cfg_count(cfg_count),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata <= mem[mem_addr];
            if (nlog < 64) rd_log[nlog] = int'(mem_addr);
            nlog = nlog + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rl(input logic [31:0] x, input int s);
        return (x << s) | (x >> (32 - s));
    endfunction

    function automatic logic [159:0] ref_sha1(input int base, input int cnt);
        logic [31:0] m [64];
        logic [31:0] h [5];
        logic [31:0] w [80];
        logic [31:0] a, b, c, dd, e, f, k, t;
        int nb;
        nb = (cnt + 18) / 16;
        for (int i = 0; i < nb * 16; i++)
            m[i] = (i < cnt) ? mem[(base + i) % MSZ] : ((i == cnt) ? 32'h8000_0000 : 32'h0);
        m[nb*16-2] = 32'h0;
        m[nb*16-1] = 32'(cnt * 32);
        h[0] = 32'h67452301; h[1] = 32'hEFCDAB89; h[2] = 32'h98BADCFE;
        h[3] = 32'h10325476; h[4] = 32'hC3D2E1F0;
        for (int bk = 0; bk < nb; bk++) begin
            for (int i = 0; i < 16; i++) w[i] = m[bk*16 + i];
            for (int i = 16; i < 80; i++) w[i] = rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
            a = h[0]; b = h[1]; c = h[2]; dd = h[3]; e = h[4];
            for (int i = 0; i < 80; i++) begin
                if (i < 20)      begin f = (b & c) | (~b & dd);           k = 32'h5A827999; end
                else if (i < 40) begin f = b ^ c ^ dd;                    k = 32'h6ED9EBA1; end
                else if (i < 60) begin f = (b & c) | (b & dd) | (c & dd); k = 32'h8F1BBCDC; end
                else             begin f = b ^ c ^ dd;                    k = 32'hCA62C1D6; end
                t = rl(a, 5) + f + e + k + w[i];
                e = dd; dd = c; c = rl(b, 30); b = a; a = t;
            end
            h[0] += a; h[1] += b; h[2] += c; h[3] += dd; h[4] += e;
        end
        return {h[0], h[1], h[2], h[3], h[4]};
    endfunction

    task automatic wr(input bit v);
        ctl_wr = 1'b1;
        ctl_wdata = v;
        @(negedge clk);
        ctl_wr = 1'b0;
        ctl_wdata = 1'b0;
    endtask

    task automatic run(input int base, input int cnt, input bit bad, input bit poke);
        logic [159:0] dg;
        logic [2:0]   held;
        int           n;
        int           addr_err;
        string        tag;
        for (int i = 0; i < cnt; i++)
            mem[(base + i) % MSZ] = (32'(i + base) * 32'h9E3779B9) ^ 32'h5A5A0F0F ^ 32'(cnt << 20);
        dg = ref_sha1(base, cnt);
        if (bad) dg[(cnt * 37) % 160] = ~dg[(cnt * 37) % 160];
        for (int j = 0; j < 5; j++) mem[(base + cnt + j) % MSZ] = dg[159 - 32*j -: 32];
        cfg_base = AW'(base);
        cfg_count = CW'(cnt);
        nlog = 0;
        wr(1'b1);
        check(stat_rdata == 3'b001, "R2 start sets request, clears done/pass", longint'(stat_rdata), 1);
        if (poke) begin
            repeat (30) @(negedge clk);
            wr(1'b1);
            check(stat_rdata == 3'b001, "R8 write 1 while running", longint'(stat_rdata), 1);
            wr(1'b0);
            check(stat_rdata == 3'b001, "R8 write 0 while running", longint'(stat_rdata), 1);
        end
        n = 0;
        while (!stat_rdata[1] && n < 3000) begin
            @(negedge clk);
            n++;
            if (!stat_rdata[1]) check(stat_rdata[2] == 1'b0, "R7 pass low before done", longint'(stat_rdata[2]), 0);
        end
        check(stat_rdata[1:0] == 2'b10, "R6 done set and request cleared", longint'(stat_rdata[1:0]), 2);
        if (cnt == 0 || cnt == 14 || cnt == 15) tag = "R9 padding boundary result";
        else if (bad) tag = "R5 corrupted digest gives fail";
        else tag = "R4 matching digest gives pass";
        check(stat_rdata[2] == !bad, tag, longint'(stat_rdata[2]), longint'(!bad));
        check(nlog == cnt + 5, "R3 read count", nlog, cnt + 5);
        addr_err = 0;
        for (int i = 0; i < cnt + 5 && i < nlog; i++)
            if (rd_log[i] != (base + i) % MSZ) addr_err++;
        check(addr_err == 0, "R3 read address order", addr_err, 0);
        held = stat_rdata;
        repeat (5) @(negedge clk);
        check(stat_rdata == held, "R10 result holds", longint'(stat_rdata), longint'(held));
        wr(1'b0);
        check(stat_rdata == held && nlog == cnt + 5, "R8 write 0 after done", longint'(stat_rdata), longint'(held));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < MSZ; i++) mem[i] = 32'(i) * 32'h01010101;
        repeat (3) @(negedge clk);
        check(stat_rdata == 3'b000, "R1 reset status", longint'(stat_rdata), 0);
        check(mem_rd_en == 1'b0, "R1 reset no read", longint'(mem_rd_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(stat_rdata == 3'b000 && nlog == 0, "R1 idle after reset", longint'(stat_rdata), 0);
        for (int c = 0; c <= 20; c++) begin
            run((c * 3) % MSZ, c, 1'b0, 1'b0);
            run((c * 5 + 7) % MSZ, c, 1'b1, 1'b0);
        end
        run(60, 6, 1'b0, 1'b0);
        run(58, 9, 1'b1, 1'b0);
        run(10, 20, 1'b0, 1'b1);
        run(30, 3, 1'b1, 1'b1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule